// File: doc/BRIEF.md
# Coprocessor Register Transfer Sequencer

This block sits between a memory data bus and one 64-bit coprocessor register. It moves one or two 32-bit data beats for each transfer. The upstream side presents one beat per cycle, together with an indication of whether it is a data beat or a control phase. For each beat the block returns a registered response one cycle later. The response says either "advance the address, another beat follows" or "transfer complete".

On stores the block supplies the outgoing bus word from the register value that is presented to it. On loads it drives a per-half write strobe and write data back toward the register file.

A wide transfer carries the full 64-bit register as two beats. An endianness input selects whether the upper or the lower half travels first. A narrow transfer moves one word. A float value lives in the upper half of the register. An integer lives in the lower half and is sign-extended to 64 bits when it is loaded. Address generation and any arithmetic use of the register are handled elsewhere.

Top module: `cxfer_seq`

## Requirements
- R1: A control phase (`beat_valid`=1, `beat_data`=0) produces, on the next cycle, `resp_valid`=1 and `resp_more`=0, with no register write and `store_word`=0. It also returns the beat counter to its first-beat state.
- R2: A cycle with `beat_valid`=0 produces, on the next cycle, `resp_valid`=0, no register write and `store_word`=0.
- R3: In a wide data transfer (`wide`=1) the response to the first beat is `resp_more`=1, and the response to the second beat is `resp_more`=0. A narrow data beat always responds with `resp_more`=0.
- R4: In a wide store with `big_endian`=1, beat 0 outputs `reg_value[63:32]` and beat 1 outputs `reg_value[31:0]`. With `big_endian`=0 the order is reversed.
- R5: In a wide load, each beat writes `load_word` into exactly one register half. The half follows the same ordering as R4: `reg_we_hi` strobes bits 63:32 and `reg_we_lo` strobes bits 31:0.
- R6: A narrow store outputs `reg_value[63:32]` when `is_float`=1 and `reg_value[31:0]` when `is_float`=0.
- R7: A narrow integer load (`is_float`=0) writes both halves. The lower half gets `load_word` and every bit of the upper half gets a copy of bit 31 of `load_word`.
- R8: A narrow float load writes only the upper half with `load_word`.
- R9: A control phase between the two beats of a wide transfer abandons that transfer. The next wide data beat is treated as beat 0.
- R10: All outputs are registered. Each response appears exactly one cycle after its beat, and reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | A beat or phase is presented this cycle |
| beat_data | input | 1 | 1 = data beat, 0 = control phase |
| wide | input | 1 | 1 = two-beat 64-bit transfer, 0 = single word |
| is_store | input | 1 | 1 = register to bus, 0 = bus to register |
| is_float | input | 1 | Narrow transfer holds a float (upper half) rather than an integer |
| big_endian | input | 1 | Upper half travels first in wide transfers |
| load_word | input | 32 | Bus word being loaded |
| reg_value | input | 64 | Current register contents, used for stores |
| resp_valid | output | 1 | Response for the previous cycle's beat |
| resp_more | output | 1 | 1 = increment and continue, 0 = done |
| store_word | output | 32 | Bus word for a store beat |
| reg_we_hi | output | 1 | Write strobe for register bits 63:32 |
| reg_we_lo | output | 1 | Write strobe for register bits 31:0 |
| reg_wdata | output | 64 | Register write data |

## Verification
The bench aims at the beat ordering in both endian modes for loads and stores. If the half selection were swapped, each half of a wide transfer would appear on the wrong beat. A control phase is injected between the two beats of a wide transfer. A counter that ignored it would treat the next beat as beat 1, report "done" too early and pick the wrong half. Narrow integer loads use negative and positive words, which catches zero-extension in place of sign-extension. Narrow float loads catch a stray lower-half write, and cycles with no beat catch spurious responses.

// File: rtl/cxfer_pkg.sv
package cxfer_pkg;
  localparam int unsigned WORD_W_DEF = 32;

  typedef struct packed {
    logic valid;
    logic data;
    logic wide;
    logic store;
    logic flt;
    logic big;
  } beat_ctl_t;
endpackage

// File: rtl/cxfer_beat_ctr.sv
module cxfer_beat_ctr (
  input  logic clk,
  input  logic rst,
  input  logic beat_valid,
  input  logic beat_data,
  input  logic wide,
  output logic mid
);
  // mid = 1 once the first beat of a wide transfer has been taken
  always_ff @(posedge clk) begin
    if (rst)             mid <= 1'b0;
    else if (beat_valid) mid <= beat_data & wide & ~mid;
  end

  p_ctrl_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_data) |=> !mid);
endmodule

// File: rtl/cxfer_half_sel.sv
module cxfer_half_sel #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned REG_W = 2 * WORD_W
) (
  input  logic              mid,
  input  logic              wide,
  input  logic              store,
  input  logic              flt,
  input  logic              big,
  input  logic [WORD_W-1:0] load_word,
  input  logic [REG_W-1:0]  reg_value,
  output logic [WORD_W-1:0] store_word,
  output logic              we_hi,
  output logic              we_lo,
  output logic [REG_W-1:0]  wdata
);
  logic upper_sel;
  logic sext;

  always_comb begin
    upper_sel  = wide ? (mid ^ big) : flt;
    sext       = !wide && !flt;
    store_word = store ? (upper_sel ? reg_value[REG_W-1:WORD_W]
                                    : reg_value[WORD_W-1:0])
                       : '0;
    we_hi      = !store && (upper_sel || sext);
    we_lo      = !store && !upper_sel;
    wdata      = sext ? {{WORD_W{load_word[WORD_W-1]}}, load_word}
                      : {load_word, load_word};
  end
endmodule

// File: rtl/cxfer_resp_reg.sv
module cxfer_resp_reg #(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned REG_W = 2 * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  cxfer_pkg::beat_ctl_t ctl,
  input  logic                 mid,
  input  logic [WORD_W-1:0]    sw_in,
  input  logic                 we_hi_in,
  input  logic                 we_lo_in,
  input  logic [REG_W-1:0]     wd_in,
  output logic                 resp_valid,
  output logic                 resp_more,
  output logic [WORD_W-1:0]    store_word,
  output logic                 reg_we_hi,
  output logic                 reg_we_lo,
  output logic [REG_W-1:0]     reg_wdata
);
  logic take;

  assign take = ctl.valid && ctl.data;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_more  <= 1'b0;
      store_word <= '0;
      reg_we_hi  <= 1'b0;
      reg_we_lo  <= 1'b0;
      reg_wdata  <= '0;
    end else begin
      resp_valid <= ctl.valid;
      resp_more  <= take && ctl.wide && !mid;
      store_word <= take ? sw_in : '0;
      reg_we_hi  <= take && we_hi_in;
      reg_we_lo  <= take && we_lo_in;
      reg_wdata  <= take ? wd_in : '0;
    end
  end
endmodule

// File: rtl/cxfer_seq.sv
module cxfer_seq #(
  parameter int unsigned WORD_W = cxfer_pkg::WORD_W_DEF,
  localparam int unsigned REG_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_valid,
  input  logic              beat_data,
  input  logic              wide,
  input  logic              is_store,
  input  logic              is_float,
  input  logic              big_endian,
  input  logic [WORD_W-1:0] load_word,
  input  logic [REG_W-1:0]  reg_value,
  output logic              resp_valid,
  output logic              resp_more,
  output logic [WORD_W-1:0] store_word,
  output logic              reg_we_hi,
  output logic              reg_we_lo,
  output logic [REG_W-1:0]  reg_wdata
);
  cxfer_pkg::beat_ctl_t ctl;
  logic              mid;
  logic [WORD_W-1:0] sw_c;
  logic              we_hi_c, we_lo_c;
  logic [REG_W-1:0]  wd_c;

  assign ctl = '{valid: beat_valid, data: beat_data, wide: wide,
                 store: is_store, flt: is_float, big: big_endian};

  cxfer_beat_ctr u_ctr (
    .clk(clk), .rst(rst), .beat_valid(beat_valid),
    .beat_data(beat_data), .wide(wide), .mid(mid)
  );

  cxfer_half_sel #(.WORD_W(WORD_W)) u_sel (
    .mid(mid), .wide(wide), .store(is_store), .flt(is_float),
    .big(big_endian), .load_word(load_word), .reg_value(reg_value),
    .store_word(sw_c), .we_hi(we_hi_c), .we_lo(we_lo_c), .wdata(wd_c)
  );

  cxfer_resp_reg #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst(rst), .ctl(ctl), .mid(mid), .sw_in(sw_c),
    .we_hi_in(we_hi_c), .we_lo_in(we_lo_c), .wd_in(wd_c),
    .resp_valid(resp_valid), .resp_more(resp_more),
    .store_word(store_word), .reg_we_hi(reg_we_hi),
    .reg_we_lo(reg_we_lo), .reg_wdata(reg_wdata)
  );

  p_ctrl_done_r1: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_data) |=> (resp_valid && !resp_more && !reg_we_hi && !reg_we_lo));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !beat_valid |=> (!resp_valid && !reg_we_hi && !reg_we_lo && store_word == '0));

  p_narrow_done_r3: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_data && !wide) |=> !resp_more);

  p_wide_load_one_half_r5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_data && wide && !is_store) |=> $countones({reg_we_hi, reg_we_lo}) == 1);

  p_sext_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_we_hi && reg_we_lo) |-> reg_wdata[REG_W-1:WORD_W] == {WORD_W{reg_wdata[WORD_W-1]}});

  p_float_load_hi_only_r8: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_data && !wide && !is_store && is_float) |=> (reg_we_hi && !reg_we_lo));
endmodule

// File: tb/cxfer_seq_tb.sv
module cxfer_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        beat_valid = 0, beat_data = 0, wide = 0, is_store = 0, is_float = 0, big_endian = 0;
  logic [31:0] load_word = '0;
  logic [63:0] reg_value = '0;
  logic        resp_valid, resp_more, reg_we_hi, reg_we_lo;
  logic [31:0] store_word;
  logic [63:0] reg_wdata;

  int n_tests = 0;
  int n_fail  = 0;
  bit m_mid   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cxfer_seq u_dut (
    .clk(clk), .rst(rst), .beat_valid(beat_valid), .beat_data(beat_data),
    .wide(wide), .is_store(is_store), .is_float(is_float), .big_endian(big_endian),
    .load_word(load_word), .reg_value(reg_value), .resp_valid(resp_valid),
    .resp_more(resp_more), .store_word(store_word), .reg_we_hi(reg_we_hi),
    .reg_we_lo(reg_we_lo), .reg_wdata(reg_wdata)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(bit v, bit d, bit w, bit s, bit f);
    if (!v)     return "R2";
    if (!d)     return "R1";
    if (w)      return s ? "R4" : "R5";
    if (s)      return "R6";
    return f ? "R8" : "R7";
  endfunction

  // drive at negedge, sample after next posedge, compare to model
  task automatic beat(input bit v, input bit d, input bit w, input bit s,
                      input bit f, input bit be, input logic [31:0] lw,
                      input logic [63:0] rv, input string extra);
    bit up, more, ehi, elo;
    logic [31:0] esw;
    logic [63:0] ewd;
    string t;
    @(negedge clk);
    beat_valid = v; beat_data = d; wide = w; is_store = s;
    is_float = f; big_endian = be; load_word = lw; reg_value = rv;
    up   = w ? (m_mid ? !be : be) : f;
    more = v && d && w && !m_mid;
    esw  = (v && d && s) ? (up ? rv[63:32] : rv[31:0]) : 32'h0;
    ehi  = v && d && !s && (up || (!w && !f));
    elo  = v && d && !s && !up;
    ewd  = !(v && d) ? 64'h0 : ((!w && !f) ? {{32{lw[31]}}, lw} : {lw, lw});
    t = tag_of(v, d, w, s, f);
    if (extra != "") t = extra;
    if (v) m_mid = d && w && !m_mid;
    @(posedge clk); #1;
    chk(t, "resp_valid", {63'h0, resp_valid}, {63'h0, v});
    chk(w && d ? "R3" : t, "resp_more", {63'h0, resp_more}, {63'h0, more});
    chk(t, "store_word", {32'h0, store_word}, {32'h0, esw});
    chk(t, "we_hi", {63'h0, reg_we_hi}, {63'h0, ehi});
    chk(t, "we_lo", {63'h0, reg_we_lo}, {63'h0, elo});
    if (ehi) chk(t, "wdata_hi", {32'h0, reg_wdata[63:32]}, {32'h0, ewd[63:32]});
    if (elo) chk(t, "wdata_lo", {32'h0, reg_wdata[31:0]}, {32'h0, ewd[31:0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    chk("R10", "reset resp_valid", {63'h0, resp_valid}, 64'h0);
    chk("R10", "reset we", {62'h0, reg_we_hi, reg_we_lo}, 64'h0);
    chk("R10", "reset store_word", {32'h0, store_word}, 64'h0);
    // directed: wide store both endians
    beat(1,1,1,1,0,1,32'h0, 64'h11112222_33334444, "R4");
    beat(1,1,1,1,0,1,32'h0, 64'h11112222_33334444, "R4");
    beat(1,1,1,1,0,0,32'h0, 64'hAAAABBBB_CCCCDDDD, "R4");
    beat(1,1,1,1,0,0,32'h0, 64'hAAAABBBB_CCCCDDDD, "R4");
    // wide load both endians
    beat(1,1,1,0,0,1,32'hDEAD0001, 64'h0, "R5");
    beat(1,1,1,0,0,1,32'hDEAD0002, 64'h0, "R5");
    beat(1,1,1,0,0,0,32'hBEEF0001, 64'h0, "R5");
    beat(1,1,1,0,0,0,32'hBEEF0002, 64'h0, "R5");
    // narrow stores
    beat(1,1,0,1,1,0,32'h0, 64'h01234567_89ABCDEF, "R6");
    beat(1,1,0,1,0,1,32'h0, 64'h01234567_89ABCDEF, "R6");
    // narrow loads: negative and positive ints, float
    beat(1,1,0,0,0,0,32'h80000005, 64'h0, "R7");
    beat(1,1,0,0,0,1,32'h7FFFFFFF, 64'h0, "R7");
    beat(1,1,0,0,1,0,32'h3F800000, 64'h0, "R8");
    // control phase abandons wide transfer
    beat(1,1,1,1,0,1,32'h0, 64'hCAFEF00D_12345678, "R3");
    beat(1,0,0,0,0,0,32'h0, 64'h0, "R1");
    beat(1,1,1,1,0,1,32'h0, 64'h55556666_77778888, "R9");
    beat(1,1,1,1,0,1,32'h0, 64'h55556666_77778888, "R9");
    // idle
    beat(0,1,1,0,0,0,32'hFFFFFFFF, 64'hFFFF, "R2");
    // random traffic
    for (int i = 0; i < 400; i++) begin
      bit v, d, w, s, f, b;
      v = ($urandom % 8) != 0;
      d = ($urandom % 6) != 0;
      w = $urandom % 2;
      s = $urandom % 2;
      f = $urandom % 2;
      b = $urandom % 2;
      if (m_mid && v && d) w = 1;
      beat(v, d, w, s, f, b, $urandom, {$urandom, $urandom}, "");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule